// File: doc/BRIEF.md
# Segment Register Load Checker

This unit services one request at a time to place a 16-bit selector into one of six segment registers. In real and virtual-8086 modes it forms the hidden descriptor state directly from the selector with no memory traffic. In protected mode it picks the global or local descriptor table, bounds-checks the entry, and fetches the 8-byte descriptor as two 32-bit reads. It then decodes the descriptor, applies the legality rules for the register being loaded, and either fills the hidden cache or reports a fault with an error code.

The stack register and the four data registers follow different rule sets and react differently to a null selector. On success the unit writes the descriptor's upper word back to memory with the accessed flag set. For a data register this write is skipped when the flag was already set. Software-visible state is exposed through a combinational view port that reads any one cache entry.

Top module: `seg_load_unit`

## Requirements
- R1: With `op_mode`=0 (real), a load sets base = selector×16, limit = 0xFFFF, granularity 0, default size 0, valid 1 and makes no memory request; the access byte is 0x9B for CS and 0x93 for the others. Register codes are CS=0, SS=1, DS=2, ES=3, FS=4, GS=5.
- R2: With `op_mode`=1 (virtual-8086), a load behaves as in R1 except that the access-byte privilege field is 3 (0xFB for CS, 0xF3 for others).
- R3: With `op_mode`=2 (protected), selector bit 2 chooses the local table (1) or the global table (0). The index (bits 15:3) times 8, plus the table base, gives the low-word address; the high word is read at that address plus 4. A request address is held stable until accepted.
- R4: A general-protection fault (`fault_kind`=1) with code selector AND 0xFFFC is raised when index×8+7 exceeds the chosen table limit, or when the local table is chosen while `ldt_valid` is 0.
- R5: A null selector (bits 15:2 zero) loaded into SS raises a general-protection fault with code 0.
- R6: A null selector loaded into DS, ES, FS or GS completes without fault and leaves that entry with selector 0 and valid 0.
- R7: SS faults with general protection unless RPL = CPL, the descriptor is a code/data type, it is writable and not executable, and its DPL = CPL.
- R8: An otherwise legal SS load of a non-present segment raises a stack fault (`fault_kind`=2).
- R9: DS/ES/FS/GS faults with general protection for a system descriptor or execute-only code. For data or non-conforming code, RPL > DPL or CPL > DPL also faults; conforming readable code skips the privilege test.
- R10: An otherwise legal data-register load of a non-present segment raises a not-present fault (`fault_kind`=3).
- R11: Decoding uses the access byte from word1[15:8] (P bit 7, DPL bits 6:5, S bit 4, type bits 3:0), base {word1[31:24], word1[7:0], word0[31:16]}, limit {word1[19:16], word0[15:0]}, G word1[23] and D/B word1[22]. With G set the cached limit is limit×4096 plus 0xFFF, or plus 0 for expand-down data (type bit 3 = 0, bit 2 = 1).
- R12: After a legal protected load, the high word with bit 8 set is written to the entry address + 4, and the cached access byte has bit 0 set. SS always writes; a data register skips the write when bit 8 was already set.
- R13: The checks run in the order null, table bounds, type, privilege, presence; only the first failure is reported, and a faulting load leaves the target entry unchanged.
- R14: `busy` rises the cycle after a request is taken and stays high through a single-cycle `done` or `fault` pulse, never both. A protected-mode load into CS is refused with a general-protection fault, code selector AND 0xFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request, taken when `busy` is low |
| req_seg | input | 3 | Target register code |
| req_sel | input | 16 | Selector to load |
| op_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected |
| cur_cpl | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | TBL_LIM_W | Global table limit |
| ldt_valid | input | 1 | Local table descriptor is valid |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | TBL_LIM_W | Local table limit |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Fault completion pulse |
| fault_kind | output | 2 | 1 general protection, 2 stack, 3 not present |
| fault_code | output | 16 | Error code |
| view_seg | input | 3 | Register code to view |
| view_sel | output | 16 | Viewed selector |
| view_valid | output | 1 | Viewed entry valid |
| view_base | output | 32 | Viewed base |
| view_limit | output | 32 | Viewed scaled limit |
| view_access | output | 8 | Viewed access byte |
| view_gran | output | 1 | Viewed granularity |
| view_big | output | 1 | Viewed default size |

## Verification
The bench builds the unit with its default parameters: a 32-bit address and 16-bit table limits. With these, an eight-entry global table and a four-entry local table held in a small word memory are enough to reach every fault class. The limit boundary is hit exactly, with index 7 passing and index 8 failing. A memory ready that stalls one cycle in three exercises the held request. Descriptors with byte and page granularity, expand-down data, conforming code and preset accessed flags show the scaled-limit forms and both outcomes of the write-back.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
  localparam int NUM_SEG = 6;

  typedef enum logic [2:0] {
    SEG_CS = 3'd0, SEG_SS = 3'd1, SEG_DS = 3'd2,
    SEG_ES = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
  } seg_id_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_GP = 2'd1, FLT_STK = 2'd2, FLT_NP = 2'd3
  } flt_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_RQ0, ST_RS0, ST_RQ1, ST_RS1, ST_EVAL, ST_WB, ST_END
  } ld_state_e;

  typedef struct packed {
    logic        present;
    logic [1:0]  dpl;
    logic        sys_n;
    logic [3:0]  typ;
    logic [31:0] base;
    logic [31:0] lim_scaled;
    logic        gran;
    logic        big;
  } desc_t;

  typedef struct packed {
    logic [15:0] sel;
    logic        vld;
    logic [31:0] base;
    logic [31:0] lim;
    logic [7:0]  acc;
    logic        gran;
    logic        big;
  } seg_cache_t;
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_load_pkg::*;
(
  input  logic [31:0] word_lo,
  input  logic [31:0] word_hi,
  output desc_t       desc
);
  logic [19:0] raw_lim;
  logic        exp_down;
  logic [1:0]  unused_bits;

  assign unused_bits = word_hi[21:20];
  assign raw_lim     = {word_hi[19:16], word_lo[15:0]};
  assign exp_down    = !word_hi[11] && word_hi[10];

  always_comb begin
    desc.present = word_hi[15];
    desc.dpl     = word_hi[14:13];
    desc.sys_n   = word_hi[12];
    desc.typ     = word_hi[11:8];
    desc.base    = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
    desc.gran    = word_hi[23];
    desc.big     = word_hi[22];
    if (word_hi[23]) begin
      desc.lim_scaled = exp_down ? {raw_lim, 12'h000} : {raw_lim, 12'hFFF};
    end else begin
      desc.lim_scaled = {12'h000, raw_lim};
    end
  end
endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
  import seg_load_pkg::*;
(
  input  desc_t      desc,
  input  logic       to_stack,
  input  logic [1:0] rpl,
  input  logic [1:0] cpl,
  output flt_e       verdict
);
  logic exec_seg;
  logic type_bad;
  logic priv_bad;

  assign exec_seg = desc.typ[3];

  always_comb begin
    if (to_stack) begin
      type_bad = !desc.sys_n || exec_seg || !desc.typ[1];
      priv_bad = (rpl != cpl) || (desc.dpl != cpl);
    end else begin
      type_bad = !desc.sys_n || (exec_seg && !desc.typ[1]);
      priv_bad = (!exec_seg || !desc.typ[2]) && ((rpl > desc.dpl) || (cpl > desc.dpl));
    end
    if (type_bad)           verdict = FLT_GP;
    else if (priv_bad)      verdict = FLT_GP;
    else if (!desc.present) verdict = to_stack ? FLT_STK : FLT_NP;
    else                    verdict = FLT_NONE;
  end
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_load_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TBL_LIM_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [2:0]           req_seg,
  input  logic [15:0]          req_sel,
  input  logic [1:0]           op_mode,
  input  logic [1:0]           cur_cpl,
  input  logic [ADDR_W-1:0]    gdt_base,
  input  logic [TBL_LIM_W-1:0] gdt_limit,
  input  logic                 ldt_valid,
  input  logic [ADDR_W-1:0]    ldt_base,
  input  logic [TBL_LIM_W-1:0] ldt_limit,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [31:0]          mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_rdata,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic [1:0]           fault_kind,
  output logic [15:0]          fault_code,
  input  logic [2:0]           view_seg,
  output logic [15:0]          view_sel,
  output logic                 view_valid,
  output logic [31:0]          view_base,
  output logic [31:0]          view_limit,
  output logic [7:0]           view_access,
  output logic                 view_gran,
  output logic                 view_big
);
  localparam int CMP_W = (TBL_LIM_W > 16) ? TBL_LIM_W : 16;

  ld_state_e   st_q, st_d;
  seg_id_e     seg_q, seg_d;
  logic [15:0] sel_q, sel_d;
  logic [1:0]  cpl_q, cpl_d;
  logic [1:0]  mode_q, mode_d;
  logic [31:0] lo_q, lo_d, hi_q, hi_d;
  flt_e        flt_q, flt_d;
  logic [15:0] code_q, code_d;
  logic [ADDR_W-1:0] tbase_q, tbase_d;

  logic        wr_en;
  seg_id_e     wr_idx;
  seg_cache_t  wr_val;
  seg_cache_t  ent_q [NUM_SEG];

  desc_t       dec;
  flt_e        verdict;
  logic        is_stack, sel_null, use_ldt, bound_bad;
  logic [CMP_W-1:0] ent_top, tbl_lim;
  logic [ADDR_W-1:0] ent_addr;
  logic [15:0] sel_mask;

  seg_desc_decode u_dec (.word_lo(lo_q), .word_hi(hi_q), .desc(dec));

  seg_rule_check u_rule (
    .desc(dec), .to_stack(is_stack), .rpl(sel_q[1:0]), .cpl(cpl_q), .verdict(verdict)
  );

  assign is_stack  = (seg_q == SEG_SS);
  assign sel_null  = (sel_q[15:2] == 14'd0);
  assign use_ldt   = sel_q[2];
  assign sel_mask  = {sel_q[15:2], 2'b00};
  assign ent_top   = CMP_W'({sel_q[15:3], 3'b111});
  assign tbl_lim   = use_ldt ? CMP_W'(ldt_limit) : CMP_W'(gdt_limit);
  assign bound_bad = ent_top > tbl_lim;
  assign ent_addr  = tbase_q + ADDR_W'({sel_q[15:3], 3'b000});

  // next-state
  always_comb begin
    st_d    = st_q;   seg_d  = seg_q;  sel_d  = sel_q;  cpl_d   = cpl_q;
    mode_d  = mode_q; lo_d   = lo_q;   hi_d   = hi_q;   flt_d   = flt_q;
    code_d  = code_q; tbase_d = tbase_q;
    wr_en   = 1'b0;   wr_idx = seg_q;  wr_val = '0;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = ent_addr;
    mem_req_wdata = hi_q | 32'h0000_0100;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        seg_d  = seg_id_e'(req_seg);
        sel_d  = req_sel;
        cpl_d  = cur_cpl;
        mode_d = op_mode;
        flt_d  = FLT_NONE;
        code_d = 16'd0;
        st_d   = ST_PRE;
      end
      ST_PRE: begin
        st_d = ST_END;
        if (!mode_q[1]) begin
          wr_en       = 1'b1;
          wr_val.sel  = sel_q;
          wr_val.vld  = 1'b1;
          wr_val.base = {12'h000, sel_q, 4'h0};
          wr_val.lim  = 32'h0000_FFFF;
          wr_val.acc  = {1'b1, mode_q[0] ? 2'b11 : 2'b00, 1'b1,
                         (seg_q == SEG_CS) ? 4'hB : 4'h3};
        end else if (seg_q == SEG_CS) begin
          flt_d = FLT_GP; code_d = sel_mask;
        end else if (sel_null) begin
          if (is_stack) begin
            flt_d = FLT_GP; code_d = 16'd0;
          end else begin
            wr_en = 1'b1;
          end
        end else if ((use_ldt && !ldt_valid) || bound_bad) begin
          flt_d = FLT_GP; code_d = sel_mask;
        end else begin
          tbase_d = use_ldt ? ldt_base : gdt_base;
          st_d    = ST_RQ0;
        end
      end
      ST_RQ0: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_d = ST_RS0;
      end
      ST_RS0: if (mem_rsp_valid) begin
        lo_d = mem_rsp_rdata;
        st_d = ST_RQ1;
      end
      ST_RQ1: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ent_addr + ADDR_W'(4);
        if (mem_req_ready) st_d = ST_RS1;
      end
      ST_RS1: if (mem_rsp_valid) begin
        hi_d = mem_rsp_rdata;
        st_d = ST_EVAL;
      end
      ST_EVAL: begin
        if (verdict != FLT_NONE) begin
          flt_d = verdict; code_d = sel_mask; st_d = ST_END;
        end else begin
          wr_en       = 1'b1;
          wr_val.sel  = sel_q;
          wr_val.vld  = 1'b1;
          wr_val.base = dec.base;
          wr_val.lim  = dec.lim_scaled;
          wr_val.acc  = {dec.present, dec.dpl, dec.sys_n, dec.typ[3:1], 1'b1};
          wr_val.gran = dec.gran;
          wr_val.big  = dec.big;
          st_d        = (is_stack || !hi_q[8]) ? ST_WB : ST_END;
        end
      end
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = ent_addr + ADDR_W'(4);
        if (mem_req_ready) st_d = ST_END;
      end
      ST_END:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; seg_q <= SEG_CS; sel_q <= '0; cpl_q <= '0; mode_q <= '0;
      lo_q <= '0; hi_q <= '0; flt_q <= FLT_NONE; code_q <= '0; tbase_q <= '0;
    end else begin
      st_q <= st_d; seg_q <= seg_d; sel_q <= sel_d; cpl_q <= cpl_d; mode_q <= mode_d;
      lo_q <= lo_d; hi_q <= hi_d; flt_q <= flt_d; code_q <= code_d; tbase_q <= tbase_d;
    end
  end

  // hidden cache, one register bank per segment with its own enable
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (wr_en && (wr_idx == seg_id_e'(g))) begin
        ent_q[g] <= wr_val;
      end
    end
  end

  seg_cache_t view_ent;
  always_comb begin
    view_ent = '0;
    if (view_seg < 3'(NUM_SEG)) view_ent = ent_q[view_seg];
  end

  assign view_sel    = view_ent.sel;
  assign view_valid  = view_ent.vld;
  assign view_base   = view_ent.base;
  assign view_limit  = view_ent.lim;
  assign view_access = view_ent.acc;
  assign view_gran   = view_ent.gran;
  assign view_big    = view_ent.big;

  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_END) && (flt_q == FLT_NONE);
  assign fault      = (st_q == ST_END) && (flt_q != FLT_NONE);
  assign fault_kind = fault ? flt_q : FLT_NONE;
  assign fault_code = code_q;

  // R14
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  // R14
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  // R14
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> (!busy && !done && !fault));
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  // R1
  real_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mode_q[1]);
  // R8
  stk_only_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && (fault_kind == FLT_STK)) |-> (seg_q == SEG_SS));
  // R12
  wb_acc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[8]);
endmodule

// File: tb/tb_seg_load_unit.sv
module tb_seg_load_unit;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic req_valid;
  logic [2:0] req_seg;
  logic [15:0] req_sel;
  logic [1:0] op_mode, cur_cpl;
  logic [31:0] gdt_base, ldt_base;
  logic [15:0] gdt_limit, ldt_limit;
  logic ldt_valid;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic busy, done, fault;
  logic [1:0] fault_kind;
  logic [15:0] fault_code;
  logic [2:0] view_seg;
  logic [15:0] view_sel;
  logic view_valid, view_gran, view_big;
  logic [31:0] view_base, view_limit;
  logic [7:0] view_access;

  seg_load_unit dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural memory, 256 words
  logic [31:0] mem [0:255];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] wr_addr, wr_data;
  int rdy_cnt = 0;

  assign mem_req_ready = (rdy_cnt % 3) != 0;

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[9:2]] <= mem_req_wdata;
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_req_addr;
        wr_data <= mem_req_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[9:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                     input logic [7:0] a, input logic g, input logic db);
    logic [31:0] w0, w1;
    w0 = {b[15:0], l[15:0]};
    w1 = {b[31:24], g, db, 2'b00, l[19:16], a, b[23:16]};
    return {w1, w0};
  endfunction

  task automatic put(input int addr, input logic [63:0] d);
    mem[addr >> 2]       = d[31:0];
    mem[(addr >> 2) + 1] = d[63:32];
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard
  typedef struct { int kind; int code; string tag; } exp_t;
  exp_t exp_q[$];
  exp_t cur;
  logic pulse_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done || fault) begin
        if (pulse_prev) chk("R14 pulse longer than one cycle", 1, 0);
        chk("R14 busy during pulse", busy, 1);
        if (exp_q.size() == 0) begin
          chk("R14 unexpected completion", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          chk({cur.tag, " kind"}, fault ? fault_kind : 0, cur.kind);
          if (fault) chk({cur.tag, " code"}, fault_code, cur.code);
        end
      end
      pulse_prev = done || fault;
    end
  end

  task automatic load(input int seg, input logic [15:0] sel, input int mode, input int cpl,
                      input int ekind, input int ecode, input string tag);
    exp_t e;
    e.kind = ekind; e.code = ecode; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_seg = 3'(seg); req_sel = sel; op_mode = 2'(mode); cur_cpl = 2'(cpl);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!(done || fault)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic view(input int seg, input string tag, input logic [15:0] esel,
                      input logic evld, input logic [31:0] ebase, input logic [31:0] elim,
                      input logic [7:0] eacc);
    view_seg = 3'(seg);
    #1;
    chk({tag, " sel"}, view_sel, esel);
    chk({tag, " valid"}, view_valid, evld);
    if (evld) begin
      chk({tag, " base"}, view_base, ebase);
      chk({tag, " limit"}, view_limit, elim);
      chk({tag, " access"}, view_access, eacc);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int rd0, wr0;
  logic [63:0] d1, d2, d3, d7, l0;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_seg = 0; req_sel = 0; op_mode = 0; cur_cpl = 0;
    gdt_base = 32'h100; gdt_limit = 16'h003F;
    ldt_base = 32'h200; ldt_limit = 16'h001F; ldt_valid = 1'b1; view_seg = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    d1 = mk(32'h12345678, 20'h0ABCD, 8'h92, 1'b0, 1'b1);
    d2 = mk(32'h00400000, 20'h00012, 8'h93, 1'b1, 1'b0);
    d3 = mk(32'h00000000, 20'h00003, 8'h96, 1'b1, 1'b0);
    d7 = mk(32'h00000000, 20'h00FFF, 8'h9E, 1'b0, 1'b0);
    l0 = mk(32'hAB000000, 20'hFFFFF, 8'hF2, 1'b1, 1'b1);
    put(32'h108, d1); put(32'h110, d2); put(32'h118, d3);
    put(32'h120, mk(32'h0, 20'hFFFF, 8'h98, 1'b0, 1'b0));
    put(32'h128, mk(32'h0, 20'hFFFF, 8'h82, 1'b0, 1'b0));
    put(32'h130, mk(32'h0, 20'hFFFF, 8'h12, 1'b0, 1'b0));
    put(32'h138, d7);
    put(32'h200, l0);
    put(32'h208, mk(32'h0, 20'hFFFF, 8'h90, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset busy", busy, 0); chk("reset done", done, 0); chk("reset fault", fault, 0);
    view(2, "reset DS", 16'h0, 1'b0, 0, 0, 0);

    rd0 = rd_cnt;
    load(0, 16'h1234, 0, 0, 0, 0, "R1 real CS");
    view(0, "R1 real CS", 16'h1234, 1'b1, 32'h00012340, 32'h0000FFFF, 8'h9B);
    chk("R1 no memory reads", rd_cnt, rd0);
    load(3, 16'hF000, 1, 3, 0, 0, "R2 v86 ES");
    view(3, "R2 v86 ES", 16'hF000, 1'b1, 32'h000F0000, 32'h0000FFFF, 8'hF3);

    wr0 = wr_cnt;
    load(2, 16'h0008, 2, 0, 0, 0, "R3 DS gdt");
    view(2, "R11 DS decode", 16'h0008, 1'b1, 32'h12345678, 32'h0000ABCD, 8'h93);
    chk("R11 DS big", view_big, 1); chk("R11 DS gran", view_gran, 0);
    chk("R12 DS writeback count", wr_cnt, wr0 + 1);
    chk("R12 DS writeback addr", wr_addr, 32'h10C);
    chk("R12 DS writeback data", wr_data, d1[63:32] | 32'h100);

    wr0 = wr_cnt;
    load(4, 16'h0010, 2, 0, 0, 0, "R11 FS page gran");
    view(4, "R11 FS", 16'h0010, 1'b1, 32'h00400000, 32'h00012FFF, 8'h93);
    chk("R12 FS skip writeback", wr_cnt, wr0);
    load(5, 16'h0018, 2, 0, 0, 0, "R11 GS expand-down");
    view(5, "R11 GS", 16'h0018, 1'b1, 32'h0, 32'h00003000, 8'h97);

    wr0 = wr_cnt;
    load(1, 16'h0007, 2, 3, 0, 0, "R3 SS ldt");
    view(1, "R3 SS ldt", 16'h0007, 1'b1, 32'hAB000000, 32'hFFFFFFFF, 8'hF3);
    chk("R12 SS writeback addr", wr_addr, 32'h204);
    chk("R12 SS writeback count", wr_cnt, wr0 + 1);

    load(1, 16'h0003, 2, 3, 1, 0, "R5 SS null");
    view(1, "R13 SS unchanged", 16'h0007, 1'b1, 32'hAB000000, 32'hFFFFFFFF, 8'hF3);
    load(2, 16'h0002, 2, 0, 0, 0, "R6 DS null");
    view(2, "R6 DS null", 16'h0000, 1'b0, 0, 0, 0);

    load(3, 16'h0040, 2, 0, 1, 16'h0040, "R4 bound");
    view(3, "R13 ES unchanged", 16'hF000, 1'b1, 32'h000F0000, 32'h0000FFFF, 8'hF3);
    ldt_valid = 1'b0;
    load(2, 16'h0004, 2, 0, 1, 16'h0004, "R4 ldt invalid");
    ldt_valid = 1'b1;

    load(2, 16'h0020, 2, 0, 1, 16'h0020, "R9 exec-only");
    load(2, 16'h0028, 2, 0, 1, 16'h0028, "R9 system");
    load(2, 16'h000B, 2, 0, 1, 16'h0008, "R9 rpl>dpl");
    load(2, 16'h0008, 2, 3, 1, 16'h0008, "R9 cpl>dpl");
    load(2, 16'h003B, 2, 3, 0, 0, "R9 conforming");
    view(2, "R9 conforming", 16'h003B, 1'b1, 32'h0, 32'h00000FFF, 8'h9F);
    chk("R12 conforming writeback addr", wr_addr, 32'h13C);

    load(2, 16'h0030, 2, 0, 3, 16'h0030, "R10 not present");
    load(2, 16'h0033, 2, 3, 1, 16'h0030, "R13 priv before presence");
    load(1, 16'h0030, 2, 0, 2, 16'h0030, "R8 SS not present");
    load(1, 16'h000C, 2, 0, 1, 16'h000C, "R7 SS read-only");
    load(1, 16'h0009, 2, 0, 1, 16'h0008, "R7 SS rpl!=cpl");
    load(0, 16'h0008, 2, 0, 1, 16'h0008, "R14 protected CS");
    view(1, "R13 SS still unchanged", 16'h0007, 1'b1, 32'hAB000000, 32'hFFFFFFFF, 8'hF3);

    repeat (2) @(negedge clk);
    chk("R14 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule